// File: doc/BRIEF.md
# ADC Conversion Sequencer

This block sits between a byte-wide register bus and an abstract 10-bit analog-to-digital converter with eight input channels. Software programs a control/status byte to pick a channel or a group of channels and a conversion clock rate, then sets the start bit. The block divides the core clock into conversion ticks and launches each conversion with a one-cycle strobe that carries the channel number. It takes the converter's 10-bit sample five ticks later and splits it across a bank of result registers.

In single mode one channel is converted, and then the block stops by itself. In continuous mode a group of four channels is scanned in a loop until software stops it. A sticky completion flag reports the end of a conversion or of a scan pass. Software can clear that flag only by reading the control/status byte first and then writing zero to the flag.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, every register reads 0. The map is: address 0 control/status, addresses 1 to 4 upper result bytes for channel pairs 0 to 3, address 5 packed low bits. In the control/status byte, bit 7 is the flag, bit 6 enable, bit 5 start, bit 4 mode (1 = continuous), bit 3 clock select (1 = fast) and bits 2:0 the channel.
- R2: A conversion lasts 5 conversion ticks. A tick occurs every 12 core cycles with clock select 1 and every 24 with clock select 0, so the flag appears 60 or 120 cycles after the strobe.
- R3: In single mode, finishing the selected channel sets the flag and clears the start bit on the same edge.
- R4: In continuous mode, channel bit 2 picks the group 0–3 or 4–7. The group is converted in ascending order and repeated. The flag sets when the last channel of the group finishes, and start stays 1.
- R5: Writing 1 to the flag does nothing. Writing 0 clears the flag only if the control/status byte was read while the flag was set.
- R6: A result for channel c stores bits 9:2 at address 1+(c mod 4) and bits 1:0 in bits [2(c mod 4)+1 : 2(c mod 4)] of address 5. Both writes happen on one edge. Bus writes to addresses 1 to 5 are ignored.
- R7: Clearing enable forces start to 0 and abandons the running conversion. No result is stored and the flag does not change.
- R8: Writing start while a conversion runs does not restart it. A change of clock select applies from the next conversion.
- R9: `conv_start_o` pulses for one cycle on the first tick after start is set, and `conv_chan_o` holds the channel being converted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 3 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (arms the flag clear) |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i, combinational |
| conv_start_o | output | 1 | One-cycle conversion launch strobe |
| conv_chan_o | output | 3 | Channel of the current conversion |
| sample_i | input | 10 | Converter result, captured at the end of a conversion |

## Verification
The launch strobe appears one core cycle after the tick that launches a conversion. Result registers and the flag update on the fifth tick after that, which is 60 or 120 cycles after the strobe. A bus write takes effect at the first edge after it. The bench drives inputs on falling edges and keeps a behavioural model that advances on each rising edge. It compares the strobe and channel at every falling edge and compares bus reads one nanosecond after the address settles. The conversion length is also measured directly by polling the flag through a side-effect-free read, so that check does not depend on the model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;
  localparam int CH_W   = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_UP0  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_LOW  = 3'd5;

  typedef struct packed {
    logic            flag;
    logic            en;
    logic            start;
    logic            mode;   // 1: continuous scan
    logic            cks;    // 1: fast conversion clock
    logic [CH_W-1:0] ch;
  } ctrl_t;
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int DIV_FAST = 12,
  parameter int DIV_SLOW = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic fast_i,
  input  logic load_i,
  output logic tick_o
);
  localparam int CNT_W = $clog2(DIV_SLOW + 1);

  logic [CNT_W-1:0] cnt_q, div_q;

  // >= keeps the counter bounded when a shorter divide is loaded
  assign tick_o = en_i && (cnt_q >= div_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= CNT_W'(DIV_SLOW);
    end else begin
      if (!en_i || tick_o) cnt_q <= '0;
      else                 cnt_q <= cnt_q + CNT_W'(1);
      if (load_i) div_q <= fast_i ? CNT_W'(DIV_FAST) : CNT_W'(DIV_SLOW);
    end
  end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm import adc_seq_pkg::*; #(
  parameter int CONV_TICKS = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            start_i,
  input  logic            mode_i,
  input  logic [CH_W-1:0] ch_sel_i,
  input  logic            tick_i,
  output logic            conv_start_o,
  output logic [CH_W-1:0] chan_o,
  output logic            busy_o,
  output logic            complete_o,
  output logic            set_flag_o,
  output logic            clr_start_o
);
  localparam int PH_W  = $clog2(CONV_TICKS);
  localparam int IDX_W = CH_W - 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CONV_TICKS - 1);

  logic            busy_q, strobe_q;
  logic [PH_W-1:0] phase_q;
  logic [CH_W-1:0] chan_q;
  logic            launch, relaunch, last_in_grp;

  assign launch      = tick_i && !busy_q && start_i && en_i;
  assign complete_o  = tick_i && busy_q && (phase_q == PH_LAST);
  assign relaunch    = complete_o && mode_i && start_i;
  assign last_in_grp = &chan_q[IDX_W-1:0];
  assign set_flag_o  = complete_o && (!mode_i || last_in_grp);
  assign clr_start_o = complete_o && !mode_i;

  assign conv_start_o = strobe_q;
  assign chan_o       = chan_q;
  assign busy_o       = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      strobe_q <= 1'b0;
      phase_q  <= '0;
      chan_q   <= '0;
    end else if (!en_i) begin
      busy_q   <= 1'b0;
      strobe_q <= 1'b0;
      phase_q  <= '0;
    end else begin
      strobe_q <= launch || relaunch;
      if (launch) begin
        busy_q  <= 1'b1;
        phase_q <= '0;
        chan_q  <= mode_i ? {ch_sel_i[CH_W-1], {IDX_W{1'b0}}} : ch_sel_i;
      end else if (complete_o) begin
        if (relaunch) begin
          phase_q <= '0;
          chan_q  <= {ch_sel_i[CH_W-1], chan_q[IDX_W-1:0] + IDX_W'(1)};
        end else begin
          busy_q <= 1'b0;
        end
      end else if (tick_i && busy_q) begin
        phase_q <= phase_q + PH_W'(1);
      end
    end
  end
endmodule

// File: rtl/adc_regs.sv
module adc_regs import adc_seq_pkg::*; #(
  parameter int SMP_W   = 10,
  parameter int N_PAIRS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              set_flag_i,
  input  logic              clr_start_i,
  input  logic              store_i,
  input  logic [CH_W-1:0]   store_chan_i,
  input  logic [SMP_W-1:0]  store_data_i,
  output ctrl_t             ctrl_o
);
  localparam int LOW_W  = SMP_W - DATA_W;
  localparam int PAIR_W = $clog2(N_PAIRS);
  localparam logic [ADDR_W-1:0] UP_LAST = ADDR_UP0 + ADDR_W'(N_PAIRS - 1);

  ctrl_t                     ctrl_q, wr_c;
  logic                      arm_q, ctrl_wr, ctrl_rd;
  logic [DATA_W-1:0]         up_q [N_PAIRS];
  logic [LOW_W*N_PAIRS-1:0]  lo_q;
  logic [PAIR_W-1:0]         pidx;

  assign wr_c    = ctrl_t'(wdata_i);
  assign ctrl_wr = wr_i && (addr_i == ADDR_CTRL);
  assign ctrl_rd = rd_i && (addr_i == ADDR_CTRL);
  assign pidx    = store_chan_i[PAIR_W-1:0];
  assign ctrl_o  = ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      arm_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.en    <= wr_c.en;
        ctrl_q.start <= wr_c.start && wr_c.en;
        ctrl_q.mode  <= wr_c.mode;
        ctrl_q.cks   <= wr_c.cks;
        ctrl_q.ch    <= wr_c.ch;
      end
      if (clr_start_i) ctrl_q.start <= 1'b0;
      // hardware set wins; a set disarms the clear sequence
      if (set_flag_i) begin
        ctrl_q.flag <= 1'b1;
        arm_q       <= 1'b0;
      end else if (ctrl_wr && !wr_c.flag && arm_q) begin
        ctrl_q.flag <= 1'b0;
        arm_q       <= 1'b0;
      end else if (ctrl_rd && ctrl_q.flag) begin
        arm_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_PAIRS; i++) up_q[i] <= '0;
      lo_q <= '0;
    end else if (store_i) begin
      up_q[pidx] <= store_data_i[SMP_W-1 -: DATA_W];
      lo_q[int'(pidx)*LOW_W +: LOW_W] <= store_data_i[LOW_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_CTRL)     rdata_o = ctrl_q;
    else if (addr_i == ADDR_LOW) rdata_o = DATA_W'(lo_q);
    else if (addr_i >= ADDR_UP0 && addr_i <= UP_LAST)
      rdata_o = up_q[PAIR_W'(addr_i - ADDR_UP0)];
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl import adc_seq_pkg::*; #(
  parameter int DIV_FAST   = 12,
  parameter int DIV_SLOW   = 24,
  parameter int CONV_TICKS = 5,
  parameter int SMP_W      = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              conv_start_o,
  output logic [CH_W-1:0]   conv_chan_o,
  input  logic [SMP_W-1:0]  sample_i
);
  localparam int N_PAIRS = 1 << (CH_W - 1);

  ctrl_t ctrl;
  logic  en_q, start_q, mode_q, flag_q;
  logic  tick, busy, complete, set_flag, clr_start;

  assign en_q    = ctrl.en;
  assign start_q = ctrl.start;
  assign mode_q  = ctrl.mode;
  assign flag_q  = ctrl.flag;

  adc_clk_div #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
    .clk_i, .rst_ni,
    .en_i   (en_q),
    .fast_i (ctrl.cks),
    .load_i (!busy || complete),
    .tick_o (tick)
  );

  adc_seq_fsm #(.CONV_TICKS(CONV_TICKS)) u_seq (
    .clk_i, .rst_ni,
    .en_i         (en_q),
    .start_i      (start_q),
    .mode_i       (mode_q),
    .ch_sel_i     (ctrl.ch),
    .tick_i       (tick),
    .conv_start_o (conv_start_o),
    .chan_o       (conv_chan_o),
    .busy_o       (busy),
    .complete_o   (complete),
    .set_flag_o   (set_flag),
    .clr_start_o  (clr_start)
  );

  adc_regs #(.SMP_W(SMP_W), .N_PAIRS(N_PAIRS)) u_regs (
    .clk_i, .rst_ni,
    .addr_i       (bus_addr_i),
    .wr_i         (bus_wr_i),
    .rd_i         (bus_rd_i),
    .wdata_i      (bus_wdata_i),
    .rdata_o      (bus_rdata_o),
    .set_flag_i   (set_flag),
    .clr_start_i  (clr_start),
    .store_i      (complete),
    .store_chan_i (conv_chan_o),
    .store_data_i (sample_i),
    .ctrl_o       (ctrl)
  );
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       conv_start_o,
  input logic       en_q,
  input logic       start_q,
  input logic       mode_q,
  input logic       flag_q,
  input logic       busy,
  input logic       set_flag,
  input logic       bus_wr_i,
  input logic [2:0] bus_addr_i,
  input logic [7:0] bus_wdata_i
);
  assert_strobe_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);

  assert_strobe_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> busy);

  assert_single_clears_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_flag && !mode_q) |=> !start_q);

  assert_flag_sets_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_flag |=> flag_q);

  assert_start_needs_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !start_q);

  assert_disable_stops_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !busy);

  assert_flag_clear_by_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(bus_wr_i && bus_addr_i == 3'd0 && !bus_wdata_i[7]));
endmodule

bind adc_seq_ctrl adc_seq_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .conv_start_o (conv_start_o),
  .en_q         (en_q),
  .start_q      (start_q),
  .mode_q       (mode_q),
  .flag_q       (flag_q),
  .busy         (busy),
  .set_flag     (set_flag),
  .bus_wr_i     (bus_wr_i),
  .bus_addr_i   (bus_addr_i),
  .bus_wdata_i  (bus_wdata_i)
);

// File: tb/adc_seq_ctrl_bench.sv
`timescale 1ns/1ps
module adc_seq_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] bus_addr_i = '0;
  logic       bus_wr_i = 1'b0, bus_rd_i = 1'b0;
  logic [7:0] bus_wdata_i = '0;
  logic [7:0] bus_rdata_o;
  logic       conv_start_o;
  logic [2:0] conv_chan_o;
  logic [9:0] sample_i;

  int seed = 3;
  int n_run = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  function automatic int smp(int ch, int s);
    return (s * 53 + ch * 91 + 7) % 1024;
  endfunction
  assign sample_i = 10'(smp(int'(conv_chan_o), seed));

  adc_seq_ctrl u_adc_seq_ctrl (.*);

  // behavioural reference model
  int m_flag, m_en, m_start, m_mode, m_cks, m_ch, m_arm;
  int m_busy, m_phase, m_chan, m_cstart, m_cnt, m_div;
  int m_up[4];
  int m_lo[4];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_flag = 0; m_en = 0; m_start = 0; m_mode = 0; m_cks = 0; m_ch = 0; m_arm = 0;
      m_busy = 0; m_phase = 0; m_chan = 0; m_cstart = 0; m_cnt = 0; m_div = 24;
      foreach (m_up[i]) begin m_up[i] = 0; m_lo[i] = 0; end
    end else begin
      bit tick, launch, comp, relaunch, setf, clrs, load, cw, cr;
      int s;
      tick     = m_en != 0 && m_cnt >= m_div - 1;
      launch   = tick && !m_busy && m_start != 0;
      comp     = tick && m_busy != 0 && m_phase == 4;
      relaunch = comp && m_mode != 0 && m_start != 0;
      setf     = comp && (m_mode == 0 || m_chan % 4 == 3);
      clrs     = comp && m_mode == 0;
      load     = !m_busy || comp;
      s        = smp(m_chan, seed);
      cw       = bus_wr_i && bus_addr_i == 0;
      cr       = bus_rd_i && bus_addr_i == 0;
      if (comp) begin m_up[m_chan % 4] = s / 4; m_lo[m_chan % 4] = s % 4; end
      m_cnt = (!m_en || tick) ? 0 : m_cnt + 1;
      if (load) m_div = m_cks ? 12 : 24;
      if (!m_en) begin
        m_busy = 0; m_cstart = 0; m_phase = 0;
      end else begin
        m_cstart = launch || relaunch;
        if (launch) begin
          m_busy = 1; m_phase = 0; m_chan = m_mode ? (m_ch & 4) : m_ch;
        end else if (comp) begin
          if (relaunch) begin m_phase = 0; m_chan = (m_ch & 4) | ((m_chan + 1) % 4); end
          else m_busy = 0;
        end else if (tick && m_busy) m_phase++;
      end
      if (setf) begin m_flag = 1; m_arm = 0; end
      else if (cw && !bus_wdata_i[7] && m_arm) begin m_flag = 0; m_arm = 0; end
      else if (cr && m_flag) m_arm = 1;
      if (cw) begin
        m_en = bus_wdata_i[6]; m_start = bus_wdata_i[5] & bus_wdata_i[6];
        m_mode = bus_wdata_i[4]; m_cks = bus_wdata_i[3]; m_ch = bus_wdata_i[2:0];
      end
      if (clrs) m_start = 0;
    end
  end

  function automatic int m_read(int a);
    if (a == 0) return m_flag*128 + m_en*64 + m_start*32 + m_mode*16 + m_cks*8 + m_ch;
    if (a >= 1 && a <= 4) return m_up[a-1];
    if (a == 5) return m_lo[0] + m_lo[1]*4 + m_lo[2]*16 + m_lo[3]*64;
    return 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // launch strobe and channel compared on every falling edge (R9, R4)
  always @(negedge clk_i) if (rst_ni) begin
    chk("R9 strobe", int'(conv_start_o), m_cstart);
    chk("R4 channel", int'(conv_chan_o), m_chan);
  end

  task automatic wr(int a, int d);
    @(negedge clk_i); bus_addr_i = 3'(a); bus_wdata_i = 8'(d); bus_wr_i = 1'b1;
    @(posedge clk_i); #1 bus_wr_i = 1'b0;
  endtask

  task automatic rd(string req, int a);
    @(negedge clk_i); bus_addr_i = 3'(a); bus_rd_i = 1'b1;
    #1 chk(req, int'(bus_rdata_o), m_read(a));
    @(posedge clk_i); #1 bus_rd_i = 1'b0;
  endtask

  task automatic wait_strobe();
    do @(negedge clk_i); while (!conv_start_o);
  endtask

  task automatic time_conv(string req, int exp);
    int n = 0;
    bus_addr_i = 3'd0;
    do begin @(negedge clk_i); #1 n++; end while (!bus_rdata_o[7] && n < 400);
    chk(req, n, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    for (int a = 0; a < 6; a++) begin
      @(negedge clk_i); bus_addr_i = 3'(a); #1 chk("R1 reset", int'(bus_rdata_o), 0);
    end

    // single, fast clock, channel 2
    seed = 11;
    wr(0, 8'h6A);
    wait_strobe();
    chk("R9 chan", int'(conv_chan_o), 2);
    time_conv("R2 fast 60", 60);
    rd("R3 single done", 0);
    chk("R3 start cleared", int'(bus_rdata_o[5]), 0);
    rd("R6 upper pair2", 3);
    chk("R6 upper value", int'(bus_rdata_o), smp(2, 11) / 4);
    rd("R6 packed", 5);
    chk("R6 packed value", int'(bus_rdata_o), (smp(2, 11) % 4) << 4);

    // single, slow clock, channel 5; flag not cleared unarmed (rd above armed it: rearm via new set)
    seed = 20;
    wr(0, 8'h65);
    wait_strobe();
    time_conv("R2 slow 120", 120);
    wr(0, 8'h45);
    rd("R5 unarmed zero", 0);
    wr(0, 8'hC5);
    rd("R5 write one", 0);
    chk("R5 flag kept", int'(bus_rdata_o[7]), 1);
    wr(0, 8'h45);
    rd("R5 armed clear", 0);
    chk("R5 flag cleared", int'(bus_rdata_o[7]), 0);
    rd("R6 pair1", 2);
    chk("R6 ch5 value", int'(bus_rdata_o), smp(5, 20) / 4);

    // continuous, group 4-7, fast
    seed = 33;
    wr(0, 8'h7D);
    for (int k = 0; k < 5; k++) begin
      wait_strobe();
      chk("R4 scan order", int'(conv_chan_o), 4 + (k % 4));
      if (k == 1) wr(0, 8'h7D);          // R8 rewrite start while busy
      if (k == 2) wr(0, 8'h75);          // R8 slow clock from next conversion
    end
    rd("R4 flag start kept", 0);
    chk("R4 start stays", int'(bus_rdata_o[5]), 1);
    for (int a = 1; a < 6; a++) rd("R6 results", a);

    // writes to result registers ignored
    wr(5, 8'hFF);
    wr(1, 8'hA5);
    rd("R6 packed ro", 5);
    rd("R6 upper ro", 1);

    // disable during a conversion
    wr(0, 8'h00);
    seed = 44;
    wr(0, 8'h68);
    wait_strobe();
    repeat (30) @(negedge clk_i);
    wr(0, 8'h08);
    rd("R7 start forced", 0);
    chk("R7 start zero", int'(bus_rdata_o[5]), 0);
    repeat (200) @(negedge clk_i);
    rd("R7 no store", 1);
    rd("R7 flag", 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule